// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Access

This block is a single-channel SPI master controlled through six 32-bit registers. Writing a byte to the transmit register starts one full-duplex 8-bit exchange. The byte leaves on MOSI, most significant bit first, while the byte arriving on MISO is collected. The SPI mode (clock polarity and phase) and the serial clock rate come from a configuration register. The rate is the system clock divided by the product of a 4-bit base factor and a power of two with a 3-bit exponent.

When the exchange completes, the block sets a ready flag in the control register and a status bit that can drive an interrupt line. The received byte can then be read. Software also owns the chip selects: it picks one of eight active-low lines and asserts or releases it around a sequence of exchanges. A two-byte length enable bit is stored and read back, but every exchange is one byte long.

Register byte offsets:

| Offset | Register |
|--------|----------|
| 0x00 | control |
| 0x04 | configuration |
| 0x08 | transmit byte |
| 0x0C | receive byte |
| 0x10 | interrupt status |
| 0x14 | interrupt mask |

Writes take effect on the rising clock edge where `wr_en` is high. Reads are combinational from `addr`.

Top module: `spi_byte_master`

## Requirements
- R1: After reset all `cs_n` lines are 1, `sck` is 0 and `irq` is 0. The control register and the receive register read 0.
- R2: Control bit 0 asserts the chip select and control bits 4:2 choose which line. Exactly `cs_n[sel]` is driven low while bit 0 is 1, and all lines are high while bit 0 is 0.
- R3: Writing the transmit register (offset 0x08, bits 7:0) while idle starts one exchange. MOSI is sent MSB first, and the byte captured from MISO reads from offset 0x0C bits 7:0. This holds in all four modes, where configuration bit 13 is CPOL and bit 12 is CPHA. CPHA=0 samples on the leading SCK edge; CPHA=1 samples on the trailing SCK edge.
- R4: While no exchange runs, SCK rests at the CPOL level (configuration bit 13).
- R5: The base factor is configuration bits 3:0. The exponent is {bits 7:6, bit 4}, with bit 4 as the low bit. One SCK period lasts D = base × 2^exponent clocks. The ready flag becomes set 1 + 7·D + floor(D/2) clock edges after the edge that accepts the transmit write.
- R6: A base factor of 0 or 1 behaves as 2.
- R7: Control bit 1 (ready, read-only) is set when an exchange finishes and is cleared by the transmit write that starts the next one.
- R8: A transmit write during an exchange is ignored. The running exchange, its timing and the transmit readback at 0x08 do not change.
- R9: Interrupt status bit 0 (offset 0x10) is set at completion. Writing 0 to it clears it, and writing 1 leaves it unchanged. `irq` is high exactly when status bit 0 and mask bit 0 (offset 0x14) are both 1.
- R10: Configuration bit 5 (two-byte enable) is stored and read back, and an exchange still carries 8 bits.
- R11: The divide setting is captured when an exchange starts. A configuration write during the exchange does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The hardest cases to reach from the ports are register writes that arrive while an exchange is running: a second transmit byte, or a new divide setting. These must leave the running exchange untouched. The bench times such a write to land a few cycles after the start. It then measures the edge count until ready and the byte a bus-functional slave received, and compares both against the values for an undisturbed exchange. Mode coverage relies on that slave, which follows CPOL and CPHA on its own so that each mode is checked against an independent model of the wire protocol.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int BYTE_W  = 8;
  localparam int SPR_W   = 4;
  localparam int SPPR_W  = 3;
  localparam int DIV_W   = SPR_W + (1 << SPPR_W) - 1;
  localparam int CONF_W  = 14;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CONF  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 5'h14;

  // stored configuration bits: mode 13:12, divide and length enable 7:0
  localparam logic [CONF_W-1:0] CONF_KEEP = 14'h30FF;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [SPR_W-1:0]  base,
  input  logic [SPPR_W-1:0] expo,
  output logic              lead,
  output logic              trail,
  output logic              wrap,
  output logic [DIV_W-1:0]  div_lat
);
  logic [DIV_W-1:0] div_q, cnt_q, cnt_n, div_calc, half;
  logic [SPR_W-1:0] base_eff;

  always_comb begin
    base_eff = (base < SPR_W'(2)) ? SPR_W'(2) : base;
    div_calc = DIV_W'(base_eff) << expo;
    half     = div_q >> 1;
    lead     = run && (cnt_q == '0);
    trail    = run && (cnt_q == half);
    wrap     = run && (cnt_q == div_q - DIV_W'(1));
    cnt_n    = wrap ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(2);
      cnt_q <= '0;
    end else begin
      if (load) div_q <= div_calc;
      if (load)      cnt_q <= '0;
      else if (run)  cnt_q <= cnt_n;
    end
  end

  assign div_lat = div_q;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_in,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lead,
  input  logic              trail,
  input  logic              wrap,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_out
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_W - 1);

  logic              busy_q, busy_n, sck_q, sck_n, cpha_q, cpha_n;
  logic [BYTE_W-1:0] tx_q, tx_n, rx_q, rx_n, rxo_q, rxo_n, rx_shift;
  logic [BIT_W-1:0]  bit_q, bit_n;

  always_comb begin
    busy_n   = busy_q;
    sck_n    = sck_q;
    cpha_n   = cpha_q;
    tx_n     = tx_q;
    rx_n     = rx_q;
    bit_n    = bit_q;
    rxo_n    = rxo_q;
    done     = 1'b0;
    rx_shift = {rx_q[BYTE_W-2:0], miso};
    if (!busy_q) begin
      sck_n = cpol;
      if (start) begin
        busy_n = 1'b1;
        tx_n   = tx_in;
        rx_n   = '0;
        bit_n  = '0;
        cpha_n = cpha;
      end
    end else begin
      if (lead) begin
        sck_n = ~sck_q;
        if (!cpha_q)              rx_n = rx_shift;
        else if (bit_q != '0)     tx_n = {tx_q[BYTE_W-2:0], 1'b0};
      end
      if (trail) begin
        sck_n = ~sck_q;
        if (cpha_q)               rx_n = rx_shift;
        else if (bit_q != LAST)   tx_n = {tx_q[BYTE_W-2:0], 1'b0};
        if (bit_q == LAST) begin
          done   = 1'b1;
          busy_n = 1'b0;
          rxo_n  = cpha_q ? rx_shift : rx_q;
        end
      end
      if (wrap) bit_n = bit_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cpha_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      rxo_q  <= '0;
    end else begin
      busy_q <= busy_n;
      sck_q  <= sck_n;
      cpha_q <= cpha_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      bit_q  <= bit_n;
      if (done) rxo_q <= rxo_n;
    end
  end

  assign busy   = busy_q;
  assign sck    = sck_q;
  assign mosi   = tx_q[BYTE_W-1];
  assign rx_out = rxo_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int CS_NUM      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_NUM-1:0] cs_n
);
  localparam int CS_W = $clog2(CS_NUM);

  logic              rst_n_s;
  logic              cs_act_q, cs_act_n, ready_q, ready_n;
  logic              istat_q, istat_n, imask_q, imask_n;
  logic [CS_W-1:0]   cs_sel_q, cs_sel_n;
  logic [CONF_W-1:0] conf_q, conf_n;
  logic [BYTE_W-1:0] txb_q, txb_n, rx_byte;
  logic [CS_NUM-1:0] cs_n_q, cs_n_n;
  logic              wr_ctrl, wr_conf, wr_tx, wr_istat, wr_imask;
  logic              start, busy, done, lead, trail, wrap;
  logic [DIV_W-1:0]  div_lat;
  logic              unused_ok;

  spi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
  assign wr_conf  = wr_en && (addr == OFS_CONF);
  assign wr_tx    = wr_en && (addr == OFS_TX);
  assign wr_istat = wr_en && (addr == OFS_ISTAT);
  assign wr_imask = wr_en && (addr == OFS_IMASK);
  assign start    = wr_tx && !busy;
  assign unused_ok = ^wdata[DATA_W-1:CONF_W];

  spi_sck_prescaler u_div (
    .clk(clk), .rst_n(rst_n_s), .load(start), .run(busy),
    .base(conf_q[3:0]), .expo({conf_q[7:6], conf_q[4]}),
    .lead(lead), .trail(trail), .wrap(wrap), .div_lat(div_lat)
  );

  spi_shift_engine u_eng (
    .clk(clk), .rst_n(rst_n_s), .start(start), .tx_in(wdata[BYTE_W-1:0]),
    .cpol(conf_q[13]), .cpha(conf_q[12]), .lead(lead), .trail(trail),
    .wrap(wrap), .miso(miso), .busy(busy), .done(done), .sck(sck),
    .mosi(mosi), .rx_out(rx_byte)
  );

  // next-state for the register file
  always_comb begin
    cs_act_n = wr_ctrl ? wdata[0] : cs_act_q;
    cs_sel_n = wr_ctrl ? wdata[2 +: CS_W] : cs_sel_q;
    conf_n   = wr_conf ? (wdata[CONF_W-1:0] & CONF_KEEP) : conf_q;
    txb_n    = start ? wdata[BYTE_W-1:0] : txb_q;
    imask_n  = wr_imask ? wdata[0] : imask_q;
    ready_n  = done ? 1'b1 : (start ? 1'b0 : ready_q);
    istat_n  = done ? 1'b1 : ((wr_istat && !wdata[0]) ? 1'b0 : istat_q);
  end

  for (genvar gi = 0; gi < CS_NUM; gi++) begin : g_cs
    assign cs_n_n[gi] = !(cs_act_n && (cs_sel_n == CS_W'(gi)));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_act_q <= 1'b0;
      cs_sel_q <= '0;
      conf_q   <= '0;
      txb_q    <= '0;
      imask_q  <= 1'b0;
      ready_q  <= 1'b0;
      istat_q  <= 1'b0;
      cs_n_q   <= '1;
    end else begin
      if (wr_ctrl) cs_act_q <= cs_act_n;
      if (wr_ctrl) cs_sel_q <= cs_sel_n;
      if (wr_ctrl) cs_n_q   <= cs_n_n;
      if (wr_conf) conf_q   <= conf_n;
      if (start)   txb_q    <= txb_n;
      if (wr_imask) imask_q <= imask_n;
      ready_q <= ready_n;
      istat_q <= istat_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL:  rdata = DATA_W'({cs_sel_q, ready_q, cs_act_q});
      OFS_CONF:  rdata = DATA_W'(conf_q);
      OFS_TX:    rdata = DATA_W'(txb_q);
      OFS_RX:    rdata = DATA_W'(rx_byte);
      OFS_ISTAT: rdata = DATA_W'(istat_q);
      OFS_IMASK: rdata = DATA_W'(imask_q);
      default:   rdata = '0;
    endcase
  end

  assign irq  = istat_q & imask_q;
  assign cs_n = cs_n_q;
endmodule

// File: rtl/spi_byte_master_sva.sv
module spi_byte_master_sva
  import spi_byte_pkg::*;
#(
  parameter int CS_NUM = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CS_NUM-1:0] cs_n,
  input logic              sck,
  input logic              busy,
  input logic              cpol,
  input logic              start,
  input logic              ready,
  input logic              done,
  input logic              stat,
  input logic [DIV_W-1:0]  div
);
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sck == $past(cpol)));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  assert_done_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (stat && ready));

  assert_div_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div));
endmodule

bind spi_byte_master spi_byte_master_sva #(.CS_NUM(CS_NUM)) u_sva (
  .clk(clk), .rst_n(rst_n_s), .cs_n(cs_n), .sck(sck), .busy(busy),
  .cpol(conf_q[13]), .start(start), .ready(ready_q), .done(done),
  .stat(istat_q), .div(div_lat)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sck, mosi;
  logic        miso = 1'b0;
  logic [7:0]  cs_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bus-functional SPI slave
  bit         s_cpol, s_cpha, lead_e;
  logic [7:0] s_tx, s_rx;
  always @(sck) begin
    if (cs_n != 8'hFF) begin
      lead_e = (sck != s_cpol);
      if (!s_cpha) begin
        if (lead_e) s_rx = {s_rx[6:0], mosi};
        else begin s_tx = {s_tx[6:0], 1'b0}; miso = s_tx[7]; end
      end else begin
        if (lead_e) begin miso = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
        else s_rx = {s_rx[6:0], mosi};
      end
    end
  end

  // scoreboard: expected MOSI bytes, popped when completion shows on irq
  logic [7:0] exp_q[$];
  bit         mon_on = 1'b1;
  logic       irq_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mon_on && irq && !irq_d) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected completion", 32'(s_rx), 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(s_rx == e, "R3 slave received MOSI byte", 32'(s_rx), 32'(e));
      end
    end
    irq_d = irq;
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] clo(input int base, input int expo, input bit b5);
    logic [2:0] e;
    e = 3'(expo);
    return {e[2:1], b5, e[0], 4'(base)};
  endfunction

  function automatic int exp_k(input int base, input int expo);
    int d;
    d = ((base < 2) ? 2 : base) * (1 << expo);
    return 1 + 7 * d + d / 2;
  endfunction

  task automatic xfer(input logic [1:0] mode, input logic [7:0] conf_lo,
                      input logic [7:0] txb, input logic [7:0] slvb,
                      input bit poke, input logic [4:0] p_addr, input logic [31:0] p_data,
                      input bit keep_stat,
                      output int k, output logic [7:0] rxb, output logic [7:0] tx_rb,
                      output bit rdy_before, output bit rdy_at0);
    logic [31:0] r;
    bus_write(5'h04, {18'h0, mode, 4'h0, conf_lo});
    s_cpol = mode[1]; s_cpha = mode[0]; s_tx = slvb; s_rx = 8'h0; miso = slvb[7];
    bus_write(5'h00, 32'h0000_000D);
    bus_read(5'h00, r); rdy_before = r[1];
    if (mon_on) exp_q.push_back(txb);
    bus_write(5'h08, {24'h0, txb});
    k = 0; rdy_at0 = 1'b0;
    forever begin
      if (poke && k == 4) begin wr_en = 1'b1; addr = p_addr; wdata = p_data; end
      else begin wr_en = 1'b0; addr = 5'h00; end
      #1;
      if (k == 0) rdy_at0 = rdata[1];
      if (!wr_en && rdata[1]) break;
      @(negedge clk);
      k++;
      if (k > 20000) break;
    end
    wr_en = 1'b0;
    bus_read(5'h0C, r); rxb = r[7:0];
    bus_read(5'h08, r); tx_rb = r[7:0];
    bus_write(5'h00, 32'h0000_000C);
    if (!keep_stat) bus_write(5'h10, 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    int k;
    logic [7:0] rxb, trb;
    bit rb, r0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cs_n == 8'hFF, "R1 cs_n after reset", 32'(cs_n), 32'hFF);
    chk(sck == 1'b0, "R1 sck after reset", 32'(sck), 32'h0);
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    bus_read(5'h00, r); chk(r == 32'h0, "R1 control after reset", r, 32'h0);
    bus_read(5'h0C, r); chk(r == 32'h0, "R1 receive after reset", r, 32'h0);

    // R2 chip select decode
    bus_write(5'h00, (32'd5 << 2) | 32'd1); @(negedge clk);
    chk(cs_n == 8'hDF, "R2 select line 5", 32'(cs_n), 32'hDF);
    bus_write(5'h00, (32'd7 << 2) | 32'd1); @(negedge clk);
    chk(cs_n == 8'h7F, "R2 select line 7", 32'(cs_n), 32'h7F);
    bus_write(5'h00, (32'd0 << 2) | 32'd1); @(negedge clk);
    chk(cs_n == 8'hFE, "R2 select line 0", 32'(cs_n), 32'hFE);
    bus_write(5'h00, (32'd5 << 2)); @(negedge clk);
    chk(cs_n == 8'hFF, "R2 inactive releases all", 32'(cs_n), 32'hFF);

    // R4 idle level follows CPOL
    bus_write(5'h04, 32'h0000_2002); repeat (2) @(negedge clk);
    chk(sck == 1'b1, "R4 idle sck with CPOL=1", 32'(sck), 32'h1);
    bus_write(5'h04, 32'h0000_0002); repeat (2) @(negedge clk);
    chk(sck == 1'b0, "R4 idle sck with CPOL=0", 32'(sck), 32'h0);

    bus_write(5'h14, 32'h1);

    // R3/R5 the four modes
    xfer(2'd0, clo(2, 0, 0), 8'hA5, 8'h3C, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(rxb == 8'h3C, "R3 mode 0 receive", 32'(rxb), 32'h3C);
    chk(k == exp_k(2, 0), "R5 mode 0 length D=2", 32'(k), 32'(exp_k(2, 0)));
    chk(trb == 8'hA5, "R3 transmit readback", 32'(trb), 32'hA5);
    xfer(2'd1, clo(2, 0, 0), 8'h96, 8'hC3, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(rxb == 8'hC3, "R3 mode 1 receive", 32'(rxb), 32'hC3);
    xfer(2'd2, clo(3, 2, 0), 8'h0F, 8'hF0, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(rxb == 8'hF0, "R3 mode 2 receive", 32'(rxb), 32'hF0);
    chk(k == exp_k(3, 2), "R5 length D=12", 32'(k), 32'(exp_k(3, 2)));
    xfer(2'd3, clo(2, 0, 0), 8'h81, 8'h7E, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(rxb == 8'h7E, "R3 mode 3 receive", 32'(rxb), 32'h7E);
    chk(rb == 1'b1, "R7 ready still set before next write", 32'(rb), 32'h1);
    chk(r0 == 1'b0, "R7 ready cleared by transmit write", 32'(r0), 32'h0);

    // R5 split exponent field
    xfer(2'd0, clo(2, 5, 0), 8'h3A, 8'h5C, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(k == exp_k(2, 5), "R5 length D=64", 32'(k), 32'(exp_k(2, 5)));
    chk(rxb == 8'h5C, "R5 receive at slow rate", 32'(rxb), 32'h5C);

    // R6 small base factor clamps to 2
    xfer(2'd0, clo(0, 0, 0), 8'h11, 8'h22, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(k == exp_k(2, 0), "R6 base 0 acts as 2", 32'(k), 32'(exp_k(2, 0)));
    xfer(2'd1, clo(1, 1, 0), 8'h33, 8'h44, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(k == exp_k(2, 1), "R6 base 1 acts as 2", 32'(k), 32'(exp_k(2, 1)));
    chk(rxb == 8'h44, "R6 receive", 32'(rxb), 32'h44);

    // R8 transmit write during an exchange
    xfer(2'd0, clo(2, 0, 0), 8'h5A, 8'h11, 1, 5'h08, 32'h0000_00E7, 0, k, rxb, trb, rb, r0);
    chk(k == exp_k(2, 0), "R8 length undisturbed", 32'(k), 32'(exp_k(2, 0)));
    chk(rxb == 8'h11, "R8 receive undisturbed", 32'(rxb), 32'h11);
    chk(trb == 8'h5A, "R8 late byte not taken", 32'(trb), 32'h5A);

    // R11 divide change during an exchange
    xfer(2'd0, clo(2, 0, 0), 8'hC6, 8'h9D, 1, 5'h04, 32'h0000_000F, 0, k, rxb, trb, rb, r0);
    chk(k == exp_k(2, 0), "R11 captured divide kept", 32'(k), 32'(exp_k(2, 0)));
    chk(rxb == 8'h9D, "R11 receive", 32'(rxb), 32'h9D);

    // R10 two-byte enable held, length stays one byte
    bus_write(5'h04, {24'h0, clo(2, 0, 1)});
    bus_read(5'h04, r);
    chk(r == 32'h22, "R10 enable bit reads back", r, 32'h22);
    xfer(2'd0, clo(2, 0, 1), 8'hE1, 8'h1E, 0, 5'h0, 32'h0, 0, k, rxb, trb, rb, r0);
    chk(k == exp_k(2, 0), "R10 still 8 bits long", 32'(k), 32'(exp_k(2, 0)));
    chk(rxb == 8'h1E, "R10 receive", 32'(rxb), 32'h1E);

    // R9 status, mask and clearing
    mon_on = 1'b0;
    bus_write(5'h14, 32'h0);
    xfer(2'd0, clo(2, 0, 0), 8'h77, 8'h88, 0, 5'h0, 32'h0, 1, k, rxb, trb, rb, r0);
    bus_read(5'h10, r); chk(r == 32'h1, "R9 status set at completion", r, 32'h1);
    chk(irq == 1'b0, "R9 masked irq low", 32'(irq), 32'h0);
    bus_write(5'h10, 32'h1);
    bus_read(5'h10, r); chk(r == 32'h1, "R9 writing 1 keeps status", r, 32'h1);
    bus_write(5'h14, 32'h1); @(negedge clk);
    chk(irq == 1'b1, "R9 unmasked irq high", 32'(irq), 32'h1);
    bus_write(5'h10, 32'h0); @(negedge clk);
    bus_read(5'h10, r); chk(r == 32'h0, "R9 writing 0 clears status", r, 32'h0);
    chk(irq == 1'b0, "R9 irq low after clear", 32'(irq), 32'h0);

    chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule